// File: doc/BRIEF.md
# Fractional Periodic Tick Scheduler

This block turns a free-running reference count into a steady stream of periodic tick pulses. It also computes the reload value for a one-shot event timer. The source advances `FREQ` counts per second and the wanted tick rate is `HZ`. Because `FREQ` is seldom a multiple of `HZ`, each tick is spaced by the integer period. An error accumulator stretches a period by one count often enough that the long-term rate comes out exact. All time comparisons use signed differences, so the block keeps working when the 32-bit count wraps.

Software or a neighbouring block strobes `service` whenever the event timer expires. The scheduler then latches the count as "now" and fires every tick that has fallen due, one per clock. It compares the next tick time with a second, externally supplied statistics event time and aims the one-shot duration at whichever comes sooner, measured against a fresh sample of the count. If the duration it computes is implausibly long, it reports lost time and falls back to one base period. It also moves both event times back to "now". The `init` strobe seeds both event times one base period past the current count.

Top module: `frac_tick_sched`

## Requirements
- R1: In reset and right after it, `tick`, `done`, `time_lost` and `stat_due` are 0 and `duration` is 0.
- R2: A pulse on `init` sets both the tick time and the statistics time to `ref_cnt` plus the base period P = FREQ/HZ (integer division). It also clears the error sum.
- R3: After `service`, one single-cycle `tick` pulse is issued per clock for as long as the signed 32-bit value (tick time − now) is ≤ 0. Then `done` pulses for one cycle in the clock after the last tick, or in the second clock after `service` when no tick is due.
- R4: Each tick advances the tick time by P and adds I = FREQ mod HZ to the error sum. When the sum then exceeds HZ, the tick time gains one more count and HZ is subtracted from the sum.
- R5: The target event is the statistics time when its unsigned distance from now is smaller than the tick time's distance from now. Otherwise the target is the tick time.
- R6: `duration` is the target minus `ref_cnt` as sampled in the clock that raises `done`. A result ≤ 0 (signed) is replaced by 1.
- R7: If that duration exceeds P+1, `time_lost` is set with `done`, `duration` becomes P, and both event times become the latched now.
- R8: Comparisons and distances stay correct when the count wraps past 2^32−1.
- R9: A `service` pulse that arrives while ticks are still being issued has no effect. It produces no extra tick and no second `done`.
- R10: `stat_due` is set with `done` when the signed value (statistics time − now) is ≤ 0. It is evaluated before any resynchronisation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init | input | 1 | Seed both event times from `ref_cnt` |
| ref_cnt | input | CW | Free-running reference count |
| stat_wr | input | 1 | Load `stat_next` as the statistics event time |
| stat_next | input | CW | Next statistics event time |
| service | input | 1 | Timer-expiry service request |
| tick | output | 1 | One pulse per tick fired |
| done | output | 1 | Result valid pulse |
| duration | output | CW | One-shot reload duration, held until the next `done` |
| time_lost | output | 1 | Lost-time flag, held until the next `done` |
| stat_due | output | 1 | Statistics event due, held until the next `done` |

## Verification
The vectors probe the scheduler under several patterns:
- A service just before the first tick, to confirm that seeding fires nothing early.
- Services that land exactly on a tick, to test the ≤ 0 boundary.
- A late service that needs several catch-up ticks, to test the tick count and the added count from the accumulator.
- A fresh sample taken past the target, to test the forced value of 1.
- A count that jumps backwards, to exercise the lost-time recovery and the state it leaves.

A statistics time placed closer than the tick time, one behind now and one far ahead tell apart the two ways the target can be picked and the `stat_due` flag. A seed just below the wrap point shows that distances are taken modulo 2^32. A second `service` sent during catch-up must change neither the number of ticks nor the number of `done` pulses.

// File: rtl/tsch_pkg.sv
package tsch_pkg;

   typedef enum logic [0:0] {
      ST_IDLE  = 1'b0,
      ST_CATCH = 1'b1
   } tsch_state_e;

   typedef struct packed {
      logic due;
      logic stat_due;
      logic lost;
   } tsch_flags_t;

endpackage

// File: rtl/tsch_tick_gen.sv
module tsch_tick_gen #(
   parameter int CW   = 32,
   parameter int FREQ = 32768,
   parameter int HZ   = 100
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          step,
   input  logic          resync,
   input  logic [CW-1:0] resync_val,
   output logic [CW-1:0] tick_time
);
   localparam int BASE    = FREQ / HZ;
   localparam int ERR_INC = FREQ % HZ;
   localparam int EW      = $clog2(2 * HZ + 1);

   logic extra;

   generate
      if (HZ < 1 || FREQ < HZ) begin : g_bad_rate
         $error("tsch_tick_gen: FREQ must be at least HZ and HZ positive");
      end
      if (CW < 8 || BASE + 1 >= (1 << (CW - 2))) begin : g_bad_width
         $error("tsch_tick_gen: CW too narrow for the base period");
      end

      if (ERR_INC == 0) begin : g_exact
         assign extra = 1'b0;
      end else begin : g_frac
         logic [EW-1:0] err_sum;
         logic [EW-1:0] err_add;
         assign err_add = err_sum + EW'(ERR_INC);
         assign extra   = (err_add > EW'(HZ));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               err_sum <= '0;
            else if (load)
               err_sum <= '0;
            else if (step && !resync)
               err_sum <= extra ? (err_add - EW'(HZ)) : err_add;
         end

         // R4: the sum never rests above HZ
         p_err_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
            err_sum <= EW'(HZ));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tick_time <= '0;
      else if (load)
         tick_time <= load_val + CW'(BASE);
      else if (resync)
         tick_time <= resync_val;
      else if (step)
         tick_time <= tick_time + CW'(BASE) + CW'(extra);
   end

   // R4: one tick moves the tick time by P or P+1
   p_step_adv_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && !resync) |=>
         ((tick_time - $past(tick_time)) == CW'(BASE) ||
          (tick_time - $past(tick_time)) == CW'(BASE + 1)));

   // R2: seeding places the tick one base period ahead
   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (tick_time - $past(load_val)) == CW'(BASE));

endmodule

// File: rtl/tsch_event_sel.sv
module tsch_event_sel
   import tsch_pkg::*;
#(
   parameter int CW   = 32,
   parameter int BASE = 327
) (
   input  logic [CW-1:0] tick_time,
   input  logic [CW-1:0] stat_time,
   input  logic [CW-1:0] now_q,
   input  logic [CW-1:0] fresh,
   output tsch_flags_t   flags,
   output logic [CW-1:0] dur
);
   logic [CW-1:0] dist_t;
   logic [CW-1:0] dist_s;
   logic [CW-1:0] target;
   logic [CW-1:0] raw;
   logic [CW-1:0] clamped;

   always_comb begin
      dist_t  = tick_time - now_q;
      dist_s  = stat_time - now_q;
      target  = (dist_t < dist_s) ? tick_time : stat_time;
      raw     = target - fresh;
      clamped = (raw == '0 || raw[CW-1]) ? CW'(1) : raw;

      flags.due      = (dist_t == '0) || dist_t[CW-1];
      flags.stat_due = (dist_s == '0) || dist_s[CW-1];
      flags.lost     = (clamped > CW'(BASE + 1));
      dur            = flags.lost ? CW'(BASE) : clamped;
   end

endmodule

// File: rtl/tsch_ctl.sv
module tsch_ctl
   import tsch_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        init,
   input  logic        service,
   input  logic        due,
   output tsch_state_e state,
   output logic        capture,
   output logic        step,
   output logic        finish
);
   always_comb begin
      capture = (state == ST_IDLE)  && service && !init;
      step    = (state == ST_CATCH) && due     && !init;
      finish  = (state == ST_CATCH) && !due    && !init;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state <= ST_IDLE;
      else if (init)
         state <= ST_IDLE;
      else if (capture)
         state <= ST_CATCH;
      else if (finish)
         state <= ST_IDLE;
   end

   // R3: a finished pass always returns to idle
   p_finish_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      finish |=> state == ST_IDLE);

   // R9: a request while busy does not restart the pass
   p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CATCH && service && due && !init) |=> state == ST_CATCH);

endmodule

// File: rtl/frac_tick_sched.sv
module frac_tick_sched
   import tsch_pkg::*;
#(
   parameter int CW   = 32,
   parameter int FREQ = 32768,
   parameter int HZ   = 100
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          init,
   input  logic [CW-1:0] ref_cnt,
   input  logic          stat_wr,
   input  logic [CW-1:0] stat_next,
   input  logic          service,
   output logic          tick,
   output logic          done,
   output logic [CW-1:0] duration,
   output logic          time_lost,
   output logic          stat_due
);
   localparam int BASE = FREQ / HZ;

   tsch_state_e   state;
   logic          capture;
   logic          step;
   logic          finish;
   logic [CW-1:0] now_q;
   logic [CW-1:0] stat_time;
   logic [CW-1:0] tick_time;
   logic [CW-1:0] dur_c;
   tsch_flags_t   flags;
   logic          resync;

   assign resync = finish && flags.lost;

   tsch_ctl u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .init    (init),
      .service (service),
      .due     (flags.due),
      .state   (state),
      .capture (capture),
      .step    (step),
      .finish  (finish)
   );

   tsch_tick_gen #(
      .CW   (CW),
      .FREQ (FREQ),
      .HZ   (HZ)
   ) u_tick_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (init),
      .load_val   (ref_cnt),
      .step       (step),
      .resync     (resync),
      .resync_val (now_q),
      .tick_time  (tick_time)
   );

   tsch_event_sel #(
      .CW   (CW),
      .BASE (BASE)
   ) u_event_sel (
      .tick_time (tick_time),
      .stat_time (stat_time),
      .now_q     (now_q),
      .fresh     (ref_cnt),
      .flags     (flags),
      .dur       (dur_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         now_q     <= '0;
         stat_time <= '0;
      end else begin
         if (capture)
            now_q <= ref_cnt;
         if (init)
            stat_time <= ref_cnt + CW'(BASE);
         else if (resync)
            stat_time <= now_q;
         else if (stat_wr)
            stat_time <= stat_next;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick      <= 1'b0;
         done      <= 1'b0;
         duration  <= '0;
         time_lost <= 1'b0;
         stat_due  <= 1'b0;
      end else begin
         tick <= step;
         done <= finish;
         if (finish) begin
            duration  <= dur_c;
            time_lost <= flags.lost;
            stat_due  <= flags.stat_due;
         end
      end
   end

   // R6: a reported duration is at least 1 and at most P+1
   p_dur_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (duration >= CW'(1) && duration <= CW'(BASE + 1)));

   // R7: lost time falls back to exactly one base period
   p_lost_dur_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && time_lost) |-> duration == CW'(BASE));

   // R7: after recovery both event times sit at the latched now
   p_resync_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (resync && !init) |=> (tick_time == now_q && stat_time == now_q));

   // R3: ticks and the result strobe never overlap
   p_tick_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({tick, done}));

   // R9: one result strobe per pass
   p_single_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

// File: tb/test_frac_tick_sched.sv
module test_frac_tick_sched;

   localparam int CW   = 32;
   localparam int FREQ = 32768;
   localparam int HZ   = 100;
   localparam int P    = FREQ / HZ;
   localparam int I    = FREQ % HZ;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          init = 1'b0;
   logic [CW-1:0] ref_cnt = '0;
   logic          stat_wr = 1'b0;
   logic [CW-1:0] stat_next = '0;
   logic          service = 1'b0;
   logic          tick;
   logic          done;
   logic [CW-1:0] duration;
   logic          time_lost;
   logic          stat_due;

   always #2 clk = ~clk;

   frac_tick_sched #(.CW(CW), .FREQ(FREQ), .HZ(HZ)) i_frac_tick_sched (
      .clk       (clk),
      .rst_n     (rst_n),
      .init      (init),
      .ref_cnt   (ref_cnt),
      .stat_wr   (stat_wr),
      .stat_next (stat_next),
      .service   (service),
      .tick      (tick),
      .done      (done),
      .duration  (duration),
      .time_lost (time_lost),
      .stat_due  (stat_due)
   );

   int  checks = 0;
   int  failures = 0;
   bit  finished = 1'b0;

   // model state, written from the requirements
   logic [31:0] m_tick;
   logic [31:0] m_stat;
   int          m_err;

   typedef struct packed {
      logic        is_init;
      logic        swr;
      logic [31:0] sval;
      logic [31:0] svc;
      logic [31:0] fresh;
      logic [7:0]  nt;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VT [NV] = '{
      '{1'b1, 1'b0, 32'd0,     32'd1000,       32'd0,          8'd0, 4'd2},
      '{1'b0, 1'b0, 32'd0,     32'd1326,       32'd1326,       8'd0, 4'd2},
      '{1'b0, 1'b0, 32'd0,     32'd1327,       32'd1327,       8'd1, 4'd6},
      '{1'b0, 1'b1, 32'd1800,  32'd1654,       32'd1654,       8'd1, 4'd5},
      '{1'b0, 1'b0, 32'd0,     32'd1990,       32'd1990,       8'd1, 4'd4},
      '{1'b0, 1'b0, 32'd0,     32'd3000,       32'd3000,       8'd3, 4'd3},
      '{1'b0, 1'b0, 32'd0,     32'd3100,       32'd3400,       8'd0, 4'd6},
      '{1'b0, 1'b1, 32'd5000,  32'd3200,       32'd2000,       8'd0, 4'd7},
      '{1'b0, 1'b0, 32'd0,     32'd3200,       32'd3200,       8'd1, 4'd7},
      '{1'b1, 1'b0, 32'd0,     32'hFFFF_FF00,  32'd0,          8'd0, 4'd8},
      '{1'b0, 1'b1, 32'h200,   32'hFFFF_FFF0,  32'hFFFF_FFF0,  8'd0, 4'd8},
      '{1'b0, 1'b0, 32'd0,     32'h50,         32'h50,         8'd1, 4'd8}
   };

   function automatic string tag(input logic [3:0] r);
      case (r)
         4'd2:    return "R2";
         4'd3:    return "R3";
         4'd4:    return "R4";
         4'd5:    return "R5";
         4'd6:    return "R6";
         4'd7:    return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic m_init(input logic [31:0] r);
      m_tick = r + P;
      m_stat = r + P;
      m_err  = 0;
   endtask

   task automatic m_service(input logic [31:0] now, input logic [31:0] fresh,
                            output int nt, output logic [31:0] d,
                            output logic lost, output logic sd);
      logic [31:0] dt;
      logic [31:0] ds;
      logic [31:0] tgt;
      int          raw;
      nt = 0;
      while ($signed(m_tick - now) <= 0) begin
         m_tick = m_tick + P;
         m_err  = m_err + I;
         if (m_err > HZ) begin
            m_tick = m_tick + 1;
            m_err  = m_err - HZ;
         end
         nt++;
      end
      dt  = m_tick - now;
      ds  = m_stat - now;
      sd  = ($signed(ds) <= 0);
      tgt = (dt < ds) ? m_tick : m_stat;
      raw = $signed(tgt - fresh);
      if (raw <= 0) raw = 1;
      lost = (raw > P + 1);
      if (lost) begin
         raw    = P;
         m_tick = now;
         m_stat = now;
      end
      d = raw;
   endtask

   task automatic do_init(input logic [31:0] r);
      @(negedge clk);
      init = 1'b1;
      ref_cnt = r;
      @(negedge clk);
      init = 1'b0;
      m_init(r);
   endtask

   task automatic do_stat(input logic [31:0] s);
      @(negedge clk);
      stat_wr = 1'b1;
      stat_next = s;
      @(negedge clk);
      stat_wr = 1'b0;
      m_stat = s;
   endtask

   // runs one service pass; poke_busy sends a second request mid-pass
   task automatic do_service(input logic [31:0] svc, input logic [31:0] fresh,
                             input bit poke_busy,
                             output int nt, output bit got_done);
      nt = 0;
      got_done = 1'b0;
      @(negedge clk);
      ref_cnt = svc;
      service = 1'b1;
      @(negedge clk);
      service = 1'b0;
      ref_cnt = fresh;
      for (int k = 0; k < 2000 && !got_done; k++) begin
         @(negedge clk);
         service = poke_busy && (k == 0);
         if (tick) nt++;
         if (done) got_done = 1'b1;
      end
      service = 1'b0;
   endtask

   initial begin
      int          nt;
      bit          gd;
      int          ent;
      logic [31:0] ed;
      logic        el;
      logic        es;

      repeat (3) @(negedge clk);
      chk("R1 tick",      {31'd0, tick},      32'd0);
      chk("R1 done",      {31'd0, done},      32'd0);
      chk("R1 duration",  duration,           32'd0);
      chk("R1 time_lost", {31'd0, time_lost}, 32'd0);
      chk("R1 stat_due",  {31'd0, stat_due},  32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after reset", {30'd0, tick, done}, 32'd0);

      for (int v = 0; v < NV; v++) begin
         if (VT[v].is_init) begin
            do_init(VT[v].svc);
         end else begin
            if (VT[v].swr) do_stat(VT[v].sval);
            m_service(VT[v].svc, VT[v].fresh, ent, ed, el, es);
            do_service(VT[v].svc, VT[v].fresh, 1'b0, nt, gd);
            chk({tag(VT[v].req), " R3 done seen"}, {31'd0, gd}, 32'd1);
            chk({tag(VT[v].req), " R3 tick count"}, nt, VT[v].nt);
            chk({tag(VT[v].req), " R4 model tick count"}, nt, ent);
            chk({tag(VT[v].req), " R6 duration"}, duration, ed);
            chk({tag(VT[v].req), " R7 time_lost"}, {31'd0, time_lost}, {31'd0, el});
            chk({tag(VT[v].req), " R10 stat_due"}, {31'd0, stat_due}, {31'd0, es});
         end
      end

      // R9: second request during a six-tick catch-up
      do_init(32'd0);
      do_stat(32'h7FFF_0000);
      m_service(32'd2000, 32'd2000, ent, ed, el, es);
      do_service(32'd2000, 32'd2000, 1'b1, nt, gd);
      chk("R9 tick count with busy request", nt, 32'd6);
      chk("R9 duration", duration, ed);
      nt = 0;
      gd = 1'b0;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         if (tick) nt++;
         if (done) gd = 1'b1;
      end
      chk("R9 no extra tick", nt, 32'd0);
      chk("R9 no second done", {31'd0, gd}, 32'd0);

      // R3: done timing with no tick due, two clocks after the request
      @(negedge clk);
      ref_cnt = 32'd2100;
      service = 1'b1;
      @(negedge clk);
      service = 1'b0;
      chk("R3 no done one clock after request", {31'd0, done}, 32'd0);
      @(negedge clk);
      chk("R3 done two clocks after request", {31'd0, done}, 32'd1);
      chk("R3 no tick when not due", {31'd0, tick}, 32'd0);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule